// File: doc/BRIEF.md
# Two-Level Direct-Indexed Next-Hop Lookup

This block resolves a 32-bit IPv4 destination into a 15-bit next hop. It uses two direct-indexed tables, so no search is needed. The upper 24 address bits select an entry in a first table. Bit 15 of that entry decides how the entry is used. When bit 15 is clear, bits 14:0 are the final next hop. When bit 15 is set, bits 14:0 name a 256-entry block in a second table, and the last address byte picks the entry inside that block. The second table serves the few prefixes that are longer than 24 bits. A result therefore never needs more than two memory reads.

The lookup is a three-stage pipeline and accepts one address on every clock. The first stage reads the first table. The second stage reads the second table. The third stage selects the result and registers it. Results from the first table are carried through the second-table stage even when that table is not read. Every result therefore appears exactly three cycles after its address, and results leave in the order the addresses arrived. Next hop 0 means "no route".

Both tables are synchronous-read memories sized by parameters, so a small configuration can be simulated. The first table holds 2^L1_IDX_W entries and is indexed by address bits [8+L1_IDX_W-1:8]. The second table holds 2^L2_BLK_W blocks of 256 entries. The tables are filled through simple write ports.

Top module: `route_lookup_2lvl`

## Requirements
- R1: While `rst` is high, and on every cycle after it falls until a new address is accepted, `out_valid` is 0 and `out_hop` is 0. Addresses presented during reset produce no result.
- R2: Every address accepted with `in_valid` produces exactly one result with `out_valid` high, exactly 3 clock cycles later. This holds whichever table supplies the hop. No `out_valid` pulse appears without a matching input.
- R3: The first table is indexed by `in_addr[8+L1_IDX_W-1:8]`. When bit 15 of the selected entry is 0, `out_hop` equals bits 14:0 of that entry. This includes the value 0, which is passed through as "no route".
- R4: When bit 15 of the selected first-table entry is 1, the second table is read at address {entry[L2_BLK_W-1:0], in_addr[7:0]}, and `out_hop` equals that second-table entry.
- R5: For a first-table entry with bit 15 clear, the result does not depend on `in_addr[7:0]`. All 256 values of the last byte give the same hop.
- R6: Addresses issued on consecutive cycles, mixing both entry kinds and including idle gaps, produce their results in input order, each on its own cycle.
- R7: In any cycle where `out_valid` is 0, `out_hop` is 0.
- R8: Address bits 31 down to 8+L1_IDX_W do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_we | input | 1 | First-table write enable |
| l1_waddr | input | L1_IDX_W | First-table write address |
| l1_wdata | input | 16 | First-table entry: bit 15 is the extend flag, bits 14:0 are the hop or block number |
| l2_we | input | 1 | Second-table write enable |
| l2_waddr | input | L2_BLK_W+8 | Second-table write address {block, last byte} |
| l2_wdata | input | 15 | Second-table next hop |
| in_valid | input | 1 | Destination address is valid this cycle |
| in_addr | input | 32 | Destination address |
| out_valid | output | 1 | Result is valid, 3 cycles after the input |
| out_hop | output | 15 | Next hop; 0 means no route |

## Verification
There are two ways the pipeline state can go wrong. A lost or doubled valid bit shows up as an `out_valid` pulse in the wrong cycle. A misaligned flag or payload register between the stages shows up as a wrong hop for the very address involved. Either error is visible at the ports three cycles after the offending input.

The sweep covers every first-table index with every value of the last byte, issued back to back. Because of this, a wrong second-table address (swapped or truncated index bits) or a result taken from a neighbouring pipeline slot produces a mismatch within the first few hundred lookups. Idle gaps and varied upper address bits separately expose valid-tracking errors and index decoding that uses too many bits.

// File: rtl/rlk_pkg.sv
package rlk_pkg;
  localparam int unsigned RLK_ADDR_W   = 32;
  localparam int unsigned RLK_LOW_W    = 8;
  localparam int unsigned RLK_HOP_W    = 15;
  localparam int unsigned RLK_ENT_W    = RLK_HOP_W + 1;
  localparam int unsigned RLK_PREFIX_W = RLK_ADDR_W - RLK_LOW_W;

  // First-table entry: ext=1 means the payload is a second-table block number.
  typedef struct packed {
    logic                 ext;
    logic [RLK_HOP_W-1:0] payload;
  } rlk_l1_ent_t;
endpackage

// File: rtl/rlk_ram.sv
// Simple dual-port memory: one write port and one registered read port.
// The read result appears one cycle after the read address is presented.
module rlk_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rlk_ext_stage.sv
// Stage 2 of the pipeline. It takes the first-table entry and issues the
// second-table read. It also carries the flag and payload forward so that
// direct hops and extended hops leave the pipeline with the same delay.
module rlk_ext_stage
  import rlk_pkg::*;
#(
  parameter int unsigned L2_BLK_W = 3,
  localparam int unsigned L2_AW   = L2_BLK_W + RLK_LOW_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s1_valid,
  input  logic [RLK_LOW_W-1:0] s1_low,
  input  rlk_l1_ent_t          s1_ent,
  output logic                 l2_re,
  output logic [L2_AW-1:0]     l2_raddr,
  output logic                 s2_valid,
  output logic                 s2_ext,
  output logic [RLK_HOP_W-1:0] s2_hop
);
  // Second-table address: block number on top, last address byte below it.
  assign l2_raddr = {s1_ent.payload[L2_BLK_W-1:0], s1_low};
  assign l2_re    = s1_valid & s1_ent.ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_ext   <= 1'b0;
      s2_hop   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_ext   <= s1_ent.ext;
      s2_hop   <= s1_ent.payload;
    end
  end
endmodule

// File: rtl/rlk_resolve.sv
// Stage 3 of the pipeline. It chooses between the carried direct hop and
// the second-table read data, and registers the result. The hop output is
// forced to zero in any cycle where no valid result is being produced.
module rlk_resolve
  import rlk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s2_valid,
  input  logic                 s2_ext,
  input  logic [RLK_HOP_W-1:0] s2_hop,
  input  logic [RLK_HOP_W-1:0] l2_q,
  output logic                 out_valid,
  output logic [RLK_HOP_W-1:0] out_hop
);
  logic [RLK_HOP_W-1:0] sel_hop;

  always_comb begin
    sel_hop = '0;
    if (s2_valid) sel_hop = s2_ext ? l2_q : s2_hop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hop   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_hop   <= sel_hop;
    end
  end
endmodule

// File: rtl/route_lookup_2lvl.sv
// Top level: three-stage next-hop lookup.
//   Stage 1: read the first table.
//   Stage 2: read the second table when the entry's extend flag is set.
//   Stage 3: select the hop and register it.
module route_lookup_2lvl
  import rlk_pkg::*;
#(
  parameter int unsigned L1_IDX_W = 10,
  parameter int unsigned L2_BLK_W = 3,
  localparam int unsigned L2_AW   = L2_BLK_W + RLK_LOW_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  l1_we,
  input  logic [L1_IDX_W-1:0]   l1_waddr,
  input  logic [RLK_ENT_W-1:0]  l1_wdata,
  input  logic                  l2_we,
  input  logic [L2_AW-1:0]      l2_waddr,
  input  logic [RLK_HOP_W-1:0]  l2_wdata,
  input  logic                  in_valid,
  input  logic [RLK_ADDR_W-1:0] in_addr,
  output logic                  out_valid,
  output logic [RLK_HOP_W-1:0]  out_hop
);
  logic [L1_IDX_W-1:0]  l1_raddr;
  logic [RLK_ENT_W-1:0] l1_q;
  rlk_l1_ent_t          s1_ent;
  logic                 s1_valid;
  logic [RLK_LOW_W-1:0] s1_low;
  logic                 l2_re;
  logic [L2_AW-1:0]     l2_raddr;
  logic [RLK_HOP_W-1:0] l2_q;
  logic                 s2_valid;
  logic                 s2_ext;
  logic [RLK_HOP_W-1:0] s2_hop;

  // The first-table index is the low end of the 24-bit prefix.
  assign l1_raddr = in_addr[RLK_LOW_W +: L1_IDX_W];

  // Prefix bits above the implemented index range do not select an entry.
  generate
    if (L1_IDX_W < RLK_PREFIX_W) begin : g_hi_bits
      logic unused_hi_addr;
      assign unused_hi_addr = ^in_addr[RLK_ADDR_W-1:RLK_LOW_W+L1_IDX_W];
    end
  endgenerate

  rlk_ram #(.DW(RLK_ENT_W), .AW(L1_IDX_W)) i_l1_ram (
    .clk   (clk),
    .we    (l1_we),
    .waddr (l1_waddr),
    .wdata (l1_wdata),
    .re    (in_valid),
    .raddr (l1_raddr),
    .rdata (l1_q)
  );

  // Stage 1 side channel: the valid bit and the last address byte travel
  // alongside the first-table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_low   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_low   <= in_addr[RLK_LOW_W-1:0];
    end
  end

  assign s1_ent = rlk_l1_ent_t'(l1_q);

  rlk_ext_stage #(.L2_BLK_W(L2_BLK_W)) i_ext (
    .clk      (clk),
    .rst      (rst),
    .s1_valid (s1_valid),
    .s1_low   (s1_low),
    .s1_ent   (s1_ent),
    .l2_re    (l2_re),
    .l2_raddr (l2_raddr),
    .s2_valid (s2_valid),
    .s2_ext   (s2_ext),
    .s2_hop   (s2_hop)
  );

  rlk_ram #(.DW(RLK_HOP_W), .AW(L2_AW)) i_l2_ram (
    .clk   (clk),
    .we    (l2_we),
    .waddr (l2_waddr),
    .wdata (l2_wdata),
    .re    (l2_re),
    .raddr (l2_raddr),
    .rdata (l2_q)
  );

  rlk_resolve i_resolve (
    .clk       (clk),
    .rst       (rst),
    .s2_valid  (s2_valid),
    .s2_ext    (s2_ext),
    .s2_hop    (s2_hop),
    .l2_q      (l2_q),
    .out_valid (out_valid),
    .out_hop   (out_hop)
  );
endmodule

// File: rtl/rlk_checker.sv
module rlk_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [14:0] out_hop
);
  // Counts clock edges since reset, saturating at 3. The latency check is
  // only applied once three inputs taken after reset can have come through.
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: reset clears the result register.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_hop == '0));

  // R2: every output valid matches an input valid three cycles earlier.
  p_fixed_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R7: the hop output is zero whenever no result is valid.
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_hop == '0));

  // R3: a valid result carries a fully defined hop.
  p_known_hop_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_hop));
endmodule

bind route_lookup_2lvl rlk_checker i_rlk_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_hop   (out_hop)
);

// File: tb/test_route_lookup_2lvl.sv
module test_route_lookup_2lvl;
  localparam int L1W = 6;
  localparam int BLKW = 2;
  localparam int L2AW = BLKW + 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            l1_we = 1'b0;
  logic [L1W-1:0]  l1_waddr = '0;
  logic [15:0]     l1_wdata = '0;
  logic            l2_we = 1'b0;
  logic [L2AW-1:0] l2_waddr = '0;
  logic [14:0]     l2_wdata = '0;
  logic            in_valid = 1'b0;
  logic [31:0]     in_addr = '0;
  logic            out_valid;
  logic [14:0]     out_hop;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  int q_hop[$];
  int q_cyc[$];
  int q_tag[$];

  always #10 clk = ~clk;  // 50 MHz

  route_lookup_2lvl #(.L1_IDX_W(L1W), .L2_BLK_W(BLKW)) i_route_lookup_2lvl (
    .clk(clk), .rst(rst),
    .l1_we(l1_we), .l1_waddr(l1_waddr), .l1_wdata(l1_wdata),
    .l2_we(l2_we), .l2_waddr(l2_waddr), .l2_wdata(l2_wdata),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_hop(out_hop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Table contents, computed arithmetically.
  function automatic logic [15:0] l1f(input int i);
    if (i % 4 == 3) return {1'b1, 15'((i / 4) % 4 + 4 * i)};
    if (i == 10)    return 16'h0000;
    return {1'b0, 15'((i * 37 + 5) & 32767)};
  endfunction

  function automatic logic [14:0] l2f(input int j);
    if (j % 97 == 0) return 15'h0;
    return 15'((j * 13 + 256) & 32767);
  endfunction

  function automatic int expect_hop(input logic [31:0] a);
    logic [15:0] e;
    e = l1f(int'(a[8 +: L1W]));
    if (e[15]) return int'(l2f(int'({e[BLKW-1:0], a[7:0]})));
    return int'(e[14:0]);
  endfunction

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input logic [31:0] a, input int tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    q_hop.push_back(expect_hop(a));
    q_cyc.push_back(cyc + 3);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Output monitor.
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (out_valid) begin
        if (q_hop.size() == 0) begin
          check(1'b0, 2, 1, 0);  // R2: no spurious valid
        end else begin
          int eh, ec, et;
          eh = q_hop.pop_front();
          ec = q_cyc.pop_front();
          et = q_tag.pop_front();
          check(cyc == ec, 2, cyc, ec);                  // R2: fixed latency
          check(int'(out_hop) == eh, et, int'(out_hop), eh);
        end
      end else begin
        check(out_hop == '0, 7, int'(out_hop), 0);      // R7
      end
    end
  end

  initial begin
    // R1: addresses offered during reset must not produce results.
    in_valid = 1'b1;
    in_addr  = 32'h0000_0305;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, 1, int'(out_valid), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0 && out_hop == '0, 1, int'({out_valid, out_hop}), 0);  // R1
    end
    mon_on = 1'b1;

    // Load both tables through the write ports.
    for (int j = 0; j < (1 << L2AW); j++) begin
      @(negedge clk);
      l2_we = 1'b1; l2_waddr = L2AW'(j); l2_wdata = l2f(j);
      l1_we = (j < (1 << L1W));
      l1_waddr = L1W'(j); l1_wdata = l1f(j);
    end
    @(negedge clk);
    l1_we = 1'b0; l2_we = 1'b0;

    // R3, R4, R5: every index with every last byte, back to back.
    for (int i = 0; i < (1 << L1W); i++) begin
      for (int b = 0; b < 256; b++) begin
        logic [15:0] e;
        int tag;
        e = l1f(i);
        tag = e[15] ? 4 : ((b == 0) ? 3 : 5);
        send({18'h0, 6'(i), 8'(b)}, tag);
      end
    end

    // R8: upper address bits vary, so aliasing on them is exercised.
    for (int k = 0; k < 256; k++) begin
      logic [17:0] hi;
      hi = 18'(k * 32'h2F3D + 1);
      send({hi, 6'(k % 64), 8'((k * 7) % 256)}, 8);
    end

    // R6: alternate the two entry kinds, with idle gaps.
    for (int k = 0; k < 200; k++) begin
      int idx;
      idx = (k % 2 == 0) ? (3 + 4 * (k % 16)) : ((k * 5) % 64);
      send({18'h15A5, 6'(idx), 8'((k * 29) % 256)}, 6);
      if (k % 5 == 2) idle();
    end
    idle();
    repeat (6) @(negedge clk);
    check(q_hop.size() == 0, 2, q_hop.size(), 0);  // R2: every input produced an output

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule